// File: doc/BRIEF.md
# Multiplexed Bus Splitter and Command Decoder

This block sits beside a bus master whose low address byte shares its pins with the data byte, and whose top address bits share pins with status. It rebuilds a stable 20-bit address. The low byte and the top nibble are captured by a latch that follows the shared lines while the address strobe is high and freezes when the strobe drops. The middle byte is taken straight from its dedicated pins.

It also turns the space-select line and the active-low read and write strobes into four separate active-low commands: memory read, memory write, I/O read and I/O write. A data transceiver model moves bytes between the master side and the device side. Its direction comes from the direction input, and it drives only while the active-low data-enable input is low.

The design targets an FPGA fabric. Every output is registered on `clk`, so each output shows the inputs sampled at the previous rising edge. The "transparent" latch is therefore sampled: it loads on every clock edge where the strobe is high and holds on every edge where the strobe is low. Reset is synchronous and active high.

Top module: `bdm_bus_split`

## Requirements
- R1: When `ale` is 1 at a rising edge, `addr[7:0]` takes `ad_lo` and `addr[19:16]` takes `a_hi` after that edge.
- R2: When `ale` is 0 at a rising edge, `addr[7:0]` and `addr[19:16]` keep their values, even while `ad_lo` carries changing data.
- R3: `addr[15:8]` takes `a_mid` at every rising edge, whatever the value of `ale`.
- R4: With `io_sel`=1, `rd_n`=0 and `wr_n`=1, `io_rd_n` goes to 0. With `io_sel`=1, `wr_n`=0 and `rd_n`=1, `io_wr_n` goes to 0.
- R5: With `io_sel`=0, `rd_n`=0 and `wr_n`=1, `mem_rd_n` goes to 0. With `io_sel`=0, `wr_n`=0 and `rd_n`=1, `mem_wr_n` goes to 0.
- R6: At most one of the four commands is low at any time. If `rd_n` and `wr_n` are both 0, or both 1, all four commands are 1.
- R7: With `den_n`=0 and `dt_r`=1, `dev_oe`=1 and `dev_data_out` equals the `ad_lo` that was sampled, while `mst_oe`=0.
- R8: With `den_n`=0 and `dt_r`=0, `mst_oe`=1 and `mst_data_out` equals the `dev_data_in` that was sampled, while `dev_oe`=0.
- R9: With `den_n`=1, both `mst_oe` and `dev_oe` are 0, so both sides float.
- R10: After reset, `addr` is 0, all four commands are 1, and both output enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ale | input | 1 | Address strobe; the latch follows the shared lines while it is high |
| ad_lo | input | 8 | Shared low address / master data byte |
| a_mid | input | 8 | Dedicated address bits 15:8 |
| a_hi | input | 4 | Shared top address bits 19:16 (status during data) |
| io_sel | input | 1 | Space select: 1 = I/O, 0 = memory |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| dt_r | input | 1 | Direction: 1 = master to device, 0 = device to master |
| den_n | input | 1 | Transceiver enable, active low |
| dev_data_in | input | 8 | Byte driven by the device side |
| addr | output | 20 | Rebuilt address |
| mem_rd_n | output | 1 | Memory read command, active low |
| mem_wr_n | output | 1 | Memory write command, active low |
| io_rd_n | output | 1 | I/O read command, active low |
| io_wr_n | output | 1 | I/O write command, active low |
| dev_data_out | output | 8 | Byte driven toward the device side |
| dev_oe | output | 1 | Device-side drive enable |
| mst_data_out | output | 8 | Byte driven toward the master side |
| mst_oe | output | 1 | Master-side drive enable |

## Verification
The embedded assertions watch, on every cycle, four properties:
- the latch loads while the strobe is high and holds while it is low;
- no two commands are ever low together, and both strobes low give all commands high;
- the two drive enables are never both high;
- disabling the transceiver turns both drive enables off.

The bench's scenarios are needed for the rest. They show that each space and strobe pair selects the right command line. They show that the moved bytes take the correct values in each direction. They also show that the middle address byte tracks its pins independently of the strobe. Finally, they show that a held address survives many cycles of unrelated data on the shared lines.

// File: rtl/bdm_pkg.sv
package bdm_pkg;
  // Command slot index: bit0 = I/O space, bit1 = write
  typedef enum logic [1:0] {
    CMD_MEM_RD = 2'd0,
    CMD_IO_RD  = 2'd1,
    CMD_MEM_WR = 2'd2,
    CMD_IO_WR  = 2'd3
  } cmd_idx_e;
  localparam int unsigned NUM_CMDS = 4;
endpackage

// File: rtl/bdm_addr_latch.sv
module bdm_addr_latch #(
  parameter int unsigned LO_W  = 8,
  parameter int unsigned MID_W = 8,
  parameter int unsigned HI_W  = 4,
  localparam int unsigned ADDR_W = LO_W + MID_W + HI_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ale,
  input  logic [LO_W-1:0]   ad_lo,
  input  logic [MID_W-1:0]  a_mid,
  input  logic [HI_W-1:0]   a_hi,
  output logic [ADDR_W-1:0] addr
);
  logic [LO_W-1:0]  lo_q;
  logic [MID_W-1:0] mid_q;
  logic [HI_W-1:0]  hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q  <= '0;
      mid_q <= '0;
      hi_q  <= '0;
    end else begin
      mid_q <= a_mid;
      if (ale) begin
        lo_q <= ad_lo;
        hi_q <= a_hi;
      end
    end
  end

  assign addr = {hi_q, mid_q, lo_q};

  // R1: strobe high loads the shared bits
  assert_latch_load_R1: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ale)) |-> (addr[LO_W-1:0] == $past(ad_lo)
                                     && addr[ADDR_W-1 -: HI_W] == $past(a_hi)));
  // R2: strobe low holds the shared bits
  assert_latch_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(ale)) |-> ($stable(addr[LO_W-1:0])
                                      && $stable(addr[ADDR_W-1 -: HI_W])));
endmodule

// File: rtl/bdm_cmd_decode.sv
module bdm_cmd_decode
  import bdm_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                io_sel,
  input  logic                rd_n,
  input  logic                wr_n,
  output logic [NUM_CMDS-1:0] cmd_n
);
  logic rd_only, wr_only;
  assign rd_only = !rd_n && wr_n;
  assign wr_only = rd_n && !wr_n;

  for (genvar i = 0; i < NUM_CMDS; i++) begin : g_cmd
    localparam logic SPACE_IO = i[0];
    localparam logic IS_WRITE = i[1];
    logic hit;
    assign hit = (io_sel == SPACE_IO) && (IS_WRITE ? wr_only : rd_only);
    always_ff @(posedge clk) begin
      if (rst) cmd_n[i] <= 1'b1;
      else     cmd_n[i] <= !hit;
    end
  end

  // R6: never two commands active together
  assert_cmd_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~cmd_n));
  // R6: conflicting strobes give no command
  assert_cmd_conflict_R6: assert property (@(posedge clk) disable iff (rst)
    (!rd_n && !wr_n) |=> (cmd_n == {NUM_CMDS{1'b1}}));
endmodule

// File: rtl/bdm_xcvr.sv
module bdm_xcvr #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dt_r,
  input  logic              den_n,
  input  logic [DATA_W-1:0] mst_in,
  input  logic [DATA_W-1:0] dev_in,
  output logic [DATA_W-1:0] dev_out,
  output logic              dev_oe,
  output logic [DATA_W-1:0] mst_out,
  output logic              mst_oe
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dev_out <= '0;
      mst_out <= '0;
      dev_oe  <= 1'b0;
      mst_oe  <= 1'b0;
    end else begin
      dev_out <= mst_in;
      mst_out <= dev_in;
      dev_oe  <= !den_n && dt_r;
      mst_oe  <= !den_n && !dt_r;
    end
  end

  // R7, R8: never drive both directions
  assert_xcvr_one_dir_R7: assert property (@(posedge clk) disable iff (rst)
    !(dev_oe && mst_oe));
  // R9: disabled transceiver floats both sides
  assert_xcvr_float_R9: assert property (@(posedge clk) disable iff (rst)
    den_n |=> (!dev_oe && !mst_oe));
endmodule

// File: rtl/bdm_bus_split.sv
module bdm_bus_split
  import bdm_pkg::*;
#(
  parameter int unsigned LO_W  = 8,
  parameter int unsigned MID_W = 8,
  parameter int unsigned HI_W  = 4,
  localparam int unsigned ADDR_W = LO_W + MID_W + HI_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ale,
  input  logic [LO_W-1:0]   ad_lo,
  input  logic [MID_W-1:0]  a_mid,
  input  logic [HI_W-1:0]   a_hi,
  input  logic              io_sel,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              dt_r,
  input  logic              den_n,
  input  logic [LO_W-1:0]   dev_data_in,
  output logic [ADDR_W-1:0] addr,
  output logic              mem_rd_n,
  output logic              mem_wr_n,
  output logic              io_rd_n,
  output logic              io_wr_n,
  output logic [LO_W-1:0]   dev_data_out,
  output logic              dev_oe,
  output logic [LO_W-1:0]   mst_data_out,
  output logic              mst_oe
);
  logic [NUM_CMDS-1:0] cmd_n;

  bdm_addr_latch #(.LO_W(LO_W), .MID_W(MID_W), .HI_W(HI_W)) u_latch (
    .clk(clk), .rst(rst), .ale(ale), .ad_lo(ad_lo),
    .a_mid(a_mid), .a_hi(a_hi), .addr(addr)
  );

  bdm_cmd_decode u_dec (
    .clk(clk), .rst(rst), .io_sel(io_sel), .rd_n(rd_n), .wr_n(wr_n),
    .cmd_n(cmd_n)
  );

  bdm_xcvr #(.DATA_W(LO_W)) u_xcvr (
    .clk(clk), .rst(rst), .dt_r(dt_r), .den_n(den_n),
    .mst_in(ad_lo), .dev_in(dev_data_in),
    .dev_out(dev_data_out), .dev_oe(dev_oe),
    .mst_out(mst_data_out), .mst_oe(mst_oe)
  );

  assign mem_rd_n = cmd_n[CMD_MEM_RD];
  assign io_rd_n  = cmd_n[CMD_IO_RD];
  assign mem_wr_n = cmd_n[CMD_MEM_WR];
  assign io_wr_n  = cmd_n[CMD_IO_WR];
endmodule

// File: tb/test_bdm_bus_split.sv
module test_bdm_bus_split;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ale = 1'b0, io_sel = 1'b0, rd_n = 1'b1, wr_n = 1'b1, dt_r = 1'b0, den_n = 1'b1;
  logic [7:0] ad_lo = '0, a_mid = '0, dev_data_in = '0;
  logic [3:0] a_hi = '0;
  logic [19:0] addr;
  logic mem_rd_n, mem_wr_n, io_rd_n, io_wr_n, dev_oe, mst_oe;
  logic [7:0] dev_data_out, mst_data_out;

  int n_chk = 0, n_fail = 0;
  logic [7:0] e_lo = '0;
  logic [3:0] e_hi = '0;

  always #10 clk = ~clk;

  bdm_bus_split i_bdm_bus_split (
    .clk(clk), .rst(rst), .ale(ale), .ad_lo(ad_lo), .a_mid(a_mid), .a_hi(a_hi),
    .io_sel(io_sel), .rd_n(rd_n), .wr_n(wr_n), .dt_r(dt_r), .den_n(den_n),
    .dev_data_in(dev_data_in), .addr(addr), .mem_rd_n(mem_rd_n),
    .mem_wr_n(mem_wr_n), .io_rd_n(io_rd_n), .io_wr_n(io_wr_n),
    .dev_data_out(dev_data_out), .dev_oe(dev_oe),
    .mst_data_out(mst_data_out), .mst_oe(mst_oe)
  );

  // expected commands {io_wr, mem_wr, io_rd, mem_rd}, active low
  function automatic logic [3:0] exp_cmd(logic s, logic r, logic w);
    logic [3:0] c = 4'hF;
    if (!r && w) c[{1'b0, s}] = 1'b0;
    if (r && !w) c[{1'b1, s}] = 1'b0;
    return c;
  endfunction

  function automatic string cmd_tag(logic s, logic r, logic w);
    if (r == w) return "R6";
    return s ? "R4" : "R5";
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive at negedge, sample 5 ns after the following posedge
  task automatic step(logic l, logic [7:0] lo, logic [7:0] mid, logic [3:0] hi,
                      logic s, logic r, logic w, logic d, logic en, logic [7:0] dv);
    @(negedge clk);
    ale = l; ad_lo = lo; a_mid = mid; a_hi = hi; io_sel = s; rd_n = r; wr_n = w;
    dt_r = d; den_n = en; dev_data_in = dv;
    @(posedge clk);
    #5;
    if (l) begin e_lo = lo; e_hi = hi; end
    check(l ? "R1" : "R2", {addr[19:16], addr[7:0]}, {e_hi, e_lo});
    check("R3", addr[15:8], mid);
    check(cmd_tag(s, r, w), {io_wr_n, mem_wr_n, io_rd_n, mem_rd_n}, exp_cmd(s, r, w));
    if (en) check("R9", {dev_oe, mst_oe}, 2'b00);
    else if (d) begin
      check("R7", {dev_oe, mst_oe}, 2'b10);
      check("R7", dev_data_out, lo);
    end else begin
      check("R8", {dev_oe, mst_oe}, 2'b01);
      check("R8", mst_data_out, dv);
    end
  endtask

  initial begin
    #4000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #5;
    check("R10", addr, 20'h0);
    check("R10", {io_wr_n, mem_wr_n, io_rd_n, mem_rd_n}, 4'hF);
    check("R10", {dev_oe, mst_oe}, 2'b00);
    @(negedge clk); rst = 1'b0;

    // directed: address phase then hold while data runs on shared lines
    step(1, 8'h5A, 8'hC3, 4'hF, 0, 1, 1, 1, 1, 8'h00);
    step(0, 8'hA5, 8'h11, 4'h0, 0, 0, 1, 0, 0, 8'h77);  // R2, R5 mem read
    step(0, 8'h3C, 8'h22, 4'h6, 0, 1, 0, 1, 0, 8'h00);  // R5 mem write
    step(0, 8'hFF, 8'h33, 4'h9, 1, 0, 1, 0, 0, 8'h81);  // R4 io read
    step(0, 8'h00, 8'h44, 4'h3, 1, 1, 0, 1, 0, 8'h00);  // R4 io write
    step(0, 8'h99, 8'h55, 4'hA, 1, 0, 0, 1, 1, 8'h00);  // R6 both low
    step(0, 8'h99, 8'h66, 4'hA, 0, 0, 0, 0, 1, 8'h00);  // R6 both low
    step(1, 8'h00, 8'h00, 4'h0, 0, 1, 1, 0, 1, 8'h00);  // R1 zero
    step(1, 8'hFF, 8'hFF, 4'hF, 1, 1, 1, 1, 0, 8'hFF);  // R1 ones

    for (int i = 0; i < 400; i++) begin
      logic [31:0] r = $urandom;
      step(r[0] & r[1], r[15:8], r[23:16], r[27:24], r[2], r[3], r[4], r[5],
           r[6] & r[7], r[31:24]);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule